// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block holds the 256-byte internal data memory of an 8-bit microcontroller core. It also sorts every access by its addressing mode. The core presents one request per cycle. Each request has a 2-bit mode, an 8-bit address, a write flag and write data, plus the currently selected register bank.

The mode and the address together pick the target:

- **Register mode** maps a 3-bit register number into one of four 8-byte banks at the bottom of memory.
- **Direct mode** reaches the lower 128 bytes. In the upper half, direct mode is sent out on a separate special-function-register port.
- **Indirect mode** reaches the lower 128 bytes and a separate 128-byte upper RAM.
- **Bit mode** addresses one of 128 single bits held in bytes 20h to 2Fh.

Reads return data one cycle after acceptance. A bit write is carried out as a read-modify-write of the containing byte. During the write-back cycle, new requests are held off.

Top module: `iram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, and every byte of the lower region and of the upper RAM reads as zero.
- R2: Mode encoding is 00 = register, 01 = direct, 10 = indirect, 11 = bit. A register-mode access uses `req_addr[2:0]` as the register number and reaches byte `bank_sel*8 + reg`. That byte is also reachable by its plain direct or indirect address.
- R3: For addresses 00h–7Fh, direct and indirect modes reach the same byte, and the SFR strobes stay low.
- R4: A direct access to 80h–FFh raises `sfr_we` (write) or `sfr_re` (read) in the acceptance cycle, with `sfr_addr` = `req_addr` and `sfr_wdata` = `req_wdata`. The read result is the `sfr_rdata` of that cycle. Internal RAM is left unchanged.
- R5: An indirect access to 80h–FFh reaches the 128-byte upper RAM and never raises an SFR strobe.
- R6: In bit mode, `req_addr[6:0]` = b selects byte 20h + (b>>3), bit b&7, and `req_addr[7]` is ignored. A bit read returns the bit in `rd_data[0]`, with `rd_data[7:1]` = 0.
- R7: A bit write changes only the target bit of its byte. `req_ready` is 0 for exactly the one cycle after acceptance, and is 1 again afterwards.
- R8: A read accepted at one clock edge gives `rd_valid` = 1 with its data right after the next edge. `rd_valid` is 0 after any write or idle cycle.
- R9: A bit write stores `req_wdata[0]`. `req_wdata[7:1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 2 | Addressing mode (00 reg, 01 direct, 10 indirect, 11 bit) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Write data (bit 0 for bit writes) |
| bank_sel | input | 2 | Selected working-register bank |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the cycle of `sfr_re` |

## Verification
The assertions assume that the requester holds `req_valid` only through ordinary accept handshakes. They also assume that `sfr_rdata` is a pure function of `sfr_addr` within the strobe cycle. The bench keeps within both assumptions:

- It offers each request for exactly one accepting edge.
- It waits out the write-back stall before the next request.
- It models the SFR side as a fixed combinational function of the address.

Random modes, addresses, banks and data are drawn across the whole 8-bit space. This includes bit addresses with bit 7 set, and write data whose upper bits conflict with bit 0.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int BANK_W   = 2;
    localparam int REGNUM_W = 3;
    localparam int BITPOS_W = $clog2(DATA_W);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BITREG_BASE = 8'h20;

    typedef enum logic [1:0] {
        MODE_REG = 2'b00,
        MODE_DIR = 2'b01,
        MODE_IND = 2'b10,
        MODE_BIT = 2'b11
    } acc_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic                to_sfr;
        logic [ADDR_W-1:0]   phys;
        logic [BITPOS_W-1:0] bitpos;
    } decode_t;

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctrl_t;
endpackage

// File: rtl/iram_decode.sv
module iram_decode
    import iram_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W,
    parameter int RW = REGNUM_W,
    parameter int PW = BITPOS_W
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] bank,
    output logic          to_sfr,
    output logic [AW-1:0] phys,
    output logic [PW-1:0] bitpos
);
    localparam int BIT_BYTE_W = AW - 1 - PW;

    always_comb begin
        to_sfr = 1'b0;
        phys   = addr;
        bitpos = addr[PW-1:0];
        unique case (acc_mode_e'(mode))
            MODE_REG: phys = AW'({bank, addr[RW-1:0]});
            MODE_DIR: begin
                to_sfr = addr[AW-1];
                phys   = addr;
            end
            MODE_IND: phys = addr;
            MODE_BIT: phys = BITREG_BASE + AW'(addr[AW-2:PW]);
            default:  phys = addr;
        endcase
    end

    logic [BIT_BYTE_W-1:0] unused_width_probe;
    assign unused_width_probe = addr[AW-2:PW];
endmodule

// File: rtl/iram_bitops.sv
module iram_bitops #(
    parameter int W  = 8,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  byte_in,
    input  logic [PW-1:0] pos,
    input  logic          bit_val,
    output logic          sel_bit,
    output logic [W-1:0]  merged
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign merged[i] = (pos == PW'(i)) ? bit_val : byte_in[i];
    end

    assign sel_bit = byte_in[pos];
endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int W  = 8,
    parameter int AW = 8,
    parameter int N  = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [N];
    logic [W-1:0] mem_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/iram_ctrl.sv
module iram_ctrl
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_mode,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_re,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    ctrl_t cur_q, nxt_d;
    decode_t dec;

    logic              store_we;
    logic [ADDR_W-1:0] store_waddr;
    logic [DATA_W-1:0] store_wdata;
    logic [DATA_W-1:0] store_rdata;
    logic              sel_bit;
    logic [DATA_W-1:0] merged;
    logic              accept;

    iram_decode u_dec (
        .mode   (req_mode),
        .addr   (req_addr),
        .bank   (bank_sel),
        .to_sfr (dec.to_sfr),
        .phys   (dec.phys),
        .bitpos (dec.bitpos)
    );

    iram_store #(.W(DATA_W), .AW(ADDR_W), .N(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .waddr (store_waddr),
        .wdata (store_wdata),
        .raddr (dec.phys),
        .rdata (store_rdata)
    );

    iram_bitops #(.W(DATA_W), .PW(BITPOS_W)) u_bit (
        .byte_in (store_rdata),
        .pos     (dec.bitpos),
        .bit_val (req_wdata[0]),
        .sel_bit (sel_bit),
        .merged  (merged)
    );

    assign req_ready = (cur_q.state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign sfr_addr  = req_addr;
    assign sfr_wdata = req_wdata;
    assign rd_valid  = cur_q.rd_valid;
    assign rd_data   = cur_q.rd_data;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.rd_valid = 1'b0;
        store_we       = 1'b0;
        store_waddr    = dec.phys;
        store_wdata    = req_wdata;
        sfr_re         = 1'b0;
        sfr_we         = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (dec.to_sfr) begin
                        sfr_we = req_we;
                        sfr_re = !req_we;
                        if (!req_we) begin
                            nxt_d.rd_valid = 1'b1;
                            nxt_d.rd_data  = sfr_rdata;
                        end
                    end else if (acc_mode_e'(req_mode) == MODE_BIT) begin
                        if (req_we) begin
                            nxt_d.state   = ST_WB;
                            nxt_d.wb_addr = dec.phys;
                            nxt_d.wb_data = merged;
                        end else begin
                            nxt_d.rd_valid = 1'b1;
                            nxt_d.rd_data  = {{(DATA_W-1){1'b0}}, sel_bit};
                        end
                    end else begin
                        if (req_we) begin
                            store_we = 1'b1;
                        end else begin
                            nxt_d.rd_valid = 1'b1;
                            nxt_d.rd_data  = store_rdata;
                        end
                    end
                end
            end
            ST_WB: begin
                store_we    = 1'b1;
                store_waddr = cur_q.wb_addr;
                store_wdata = cur_q.wb_data;
                nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, wb_addr: '0, wb_data: '0,
                       rd_valid: 1'b0, rd_data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/iram_ctrl_chk.sv
module iram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_mode,
    input logic       req_we,
    input logic [7:0] req_addr,
    input logic       rd_valid,
    input logic       sfr_re,
    input logic       sfr_we
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r7_stall_after_bitwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_we && req_mode == 2'b11) |=> !req_ready);

    a_r7_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    a_r8_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_we) |=> rd_valid);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && !req_we) |=> !rd_valid);

    a_r4_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_re || sfr_we) |-> (acc && req_mode == 2'b01 && req_addr[7]));

    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_re && sfr_we));

    a_r5_indirect_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 2'b10) |-> !(sfr_re || sfr_we));

    a_r3_low_direct_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 2'b01 && !req_addr[7]) |-> !(sfr_re || sfr_we));
endmodule

bind iram_ctrl iram_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .sfr_re    (sfr_re),
    .sfr_we    (sfr_we)
);

// File: tb/sim_iram_ctrl.sv
`timescale 1ns/1ps
module sim_iram_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_mode = 2'b00;
    logic       req_we = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [1:0] bank_sel = 2'b00;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       sfr_re, sfr_we;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] ref_mem [256];

    always #2 clk = ~clk;

    assign sfr_rdata = sfr_addr ^ 8'hA5;

    iram_ctrl u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] phys_of(input logic [1:0] m, input logic [7:0] a,
                                           input logic [1:0] b);
        case (m)
            2'b00:   return {3'b000, b, a[2:0]};
            2'b11:   return 8'h20 + {4'h0, a[6:3]};
            default: return a;
        endcase
    endfunction

    task automatic op(input logic [1:0] m, input logic w, input logic [7:0] a,
                      input logic [7:0] d, input logic [1:0] b);
        logic [7:0] p;
        logic is_sfr;
        logic [7:0] exp;
        p = phys_of(m, a, b);
        is_sfr = (m == 2'b01) && a[7];
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_we = w;
        req_addr = a; req_wdata = d; bank_sel = b;
        #0.5;
        check(is_sfr ? "R4 sfr strobes" : (m == 2'b10 ? "R5 no strobes" : "R3 no strobes"),
              {30'd0, sfr_we, sfr_re}, {30'd0, is_sfr && w, is_sfr && !w});
        if (is_sfr) check("R4 sfr addr/data", {16'd0, sfr_addr, sfr_wdata}, {16'd0, a, d});
        if (is_sfr)          exp = a ^ 8'hA5;
        else if (m == 2'b11) exp = {7'd0, ref_mem[p][a[2:0]]};
        else                 exp = ref_mem[p];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!w) begin
            check(m == 2'b00 ? "R2 reg read" : (m == 2'b11 ? "R6 bit read" : "R8 read data"),
                  {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, exp});
        end else begin
            check("R8 no valid on write", {31'd0, rd_valid}, 32'd0);
            if (m == 2'b11) begin
                check("R7 stall", {31'd0, req_ready}, 32'd0);
                ref_mem[p][a[2:0]] = d[0];
                @(negedge clk);
                check("R7 ready back", {31'd0, req_ready}, 32'd1);
            end else if (!is_sfr) begin
                ref_mem[p] = d;
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready at reset", {31'd0, req_ready}, 32'd1);
        check("R1 no valid at reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) op(2'b10, 1'b0, 8'(i), 8'h00, 2'b00); // R1 all zero

        // R2: bank offset, seen via plain address
        op(2'b00, 1'b1, 8'h05, 8'h3C, 2'b10);
        op(2'b01, 1'b0, 8'h15, 8'h00, 2'b00);
        op(2'b00, 1'b0, 8'hFD, 8'h00, 2'b10);
        op(2'b00, 1'b0, 8'h05, 8'h00, 2'b01);
        // R3: direct write, indirect read of low region
        op(2'b01, 1'b1, 8'h7F, 8'h9E, 2'b00);
        op(2'b10, 1'b0, 8'h7F, 8'h00, 2'b00);
        // R4: direct high write goes out, RAM untouched
        op(2'b10, 1'b1, 8'h90, 8'h11, 2'b00);
        op(2'b01, 1'b1, 8'h90, 8'hEE, 2'b00);
        op(2'b10, 1'b0, 8'h90, 8'h00, 2'b00);
        op(2'b01, 1'b0, 8'h90, 8'h00, 2'b00);
        // R5: upper RAM at FFh
        op(2'b10, 1'b1, 8'hFF, 8'h5A, 2'b00);
        op(2'b10, 1'b0, 8'hFF, 8'h00, 2'b00);
        // R6/R7/R9: bit ops, addr[7] ignored, upper wdata bits ignored
        op(2'b01, 1'b1, 8'h2F, 8'h00, 2'b00);
        op(2'b11, 1'b1, 8'hFF, 8'hFE, 2'b00);
        op(2'b11, 1'b1, 8'h78, 8'h01, 2'b00);
        op(2'b01, 1'b0, 8'h2F, 8'h00, 2'b00);
        op(2'b11, 1'b0, 8'h7F, 8'h00, 2'b00);
        op(2'b11, 1'b1, 8'h7F, 8'h01, 2'b00);
        op(2'b11, 1'b0, 8'hFF, 8'h00, 2'b00);
        op(2'b10, 1'b0, 8'h2F, 8'h00, 2'b00);

        for (int i = 0; i < 3000; i++) begin
            op(2'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 2'($urandom));
        end
        for (int i = 0; i < 256; i++) op(2'b10, 1'b0, 8'(i), 8'h00, 2'b00);

        finished = 1'b1;
        finish_run();
    end
endmodule